// File: doc/BRIEF.md
# Trigger-level byte FIFO pair

This block is the buffering stage that sits between a bus register port and a serial shifter. It holds one byte FIFO for transmit and one for receive. Software pushes transmit bytes through a register write, and the shifter takes them from a valid/ready stream. The shifter delivers received bytes on a valid-only stream, and software pops them with a register read. The depth is a parameter: 64 by default, and 128 is also supported. The depth must be a power of two no larger than 128.

Each FIFO compares its fill count against a programmable 8-bit trigger level. The receive side raises a ready condition when enough bytes have arrived. The transmit side raises a refill request when few enough bytes remain. Each condition can drive a DMA request line, and each sets a sticky interrupt flag. An overflow flag and a transfer-done flag share the same status register. Each FIFO has a self-clearing soft reset, and both fill counts can be read back.

Back-pressure rules: `tx_valid` stays high, with `tx_data` held steady, until the shifter asserts `tx_ready`. A byte moves on every cycle in which both are high. The receive stream has no ready signal, so the shifter cannot be stalled. When the receive FIFO is full, a byte that arrives is lost and the loss is flagged.

Top module: `trig_fifo_pair`

## Requirements
- R1: Register word 0 (control) reads back the RX trigger in bits 7:0, the RX DMA enable in bit 8, the TX trigger in bits 23:16 and the TX DMA enable in bit 24, as last written. All of these reset to 0.
- R2: A write to word 4 pushes `reg_wdata[7:0]` into the TX FIFO. If the FIFO is full at the start of that cycle, the byte is dropped and the FIFO is left unchanged.
- R3: `tx_valid` is high whenever the TX FIFO is not empty, and `tx_data` is the oldest byte. A byte is removed only in a cycle with `tx_valid` and `tx_ready` both high, and bytes leave in the order they were written.
- R4: A cycle with `rx_in_valid` high pushes `rx_in_data`. If the RX FIFO is full at the start of that cycle, the byte is dropped and status bit 8 (overflow) is set.
- R5: Word 5 reads the oldest RX byte in bits 7:0. A read strobe to word 5 pops that byte. When the FIFO is empty, word 5 reads 0 and a strobe removes nothing.
- R6: Word 1 (fill status) holds the RX count in bits 7:0 and the TX count in bits 23:16. All other bits read 0.
- R7: The RX-ready condition holds while the RX count is at least the RX trigger. At each clock edge where it holds, status bit 0 is set.
- R8: The TX-request condition holds while the TX count is at most the TX trigger. At each clock edge where it holds, status bit 4 is set.
- R9: `dma_rx_req` equals the RX-ready condition ANDed with the RX DMA enable. `dma_tx_req` equals the TX-request condition ANDed with the TX DMA enable. Both follow the conditions in the same cycle.
- R10: Word 3 (status) reads the flags at bits 0, 4, 8 and 12. Writing 1 to a flag bit clears it. If the flag's set condition is also present at that edge, the set wins.
- R11: Word 2 (enable) holds enables at bits 0, 4, 8 and 12. `irq` is the OR of status AND enable.
- R12: Writing 1 to control bit 15 empties the RX FIFO, and writing 1 to control bit 31 empties the TX FIFO, at the edge of that write. The clear wins over a push or pop in the same cycle. The reset bit reads 1 for one cycle after the write and 0 after that.
- R13: A one-cycle pulse on `xfer_done` sets status bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX on word 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tx_valid | output | 1 | TX stream byte available |
| tx_ready | input | 1 | Shifter accepts the TX byte |
| tx_data | output | 8 | Oldest TX byte |
| rx_in_valid | input | 1 | Received byte present |
| rx_in_data | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse from the shifter |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | RX DMA request |
| dma_tx_req | output | 1 | TX DMA request |

## Verification
Read data, the TX stream outputs and the DMA lines are combinational from registered counts and settings, so they are due in the same cycle that any edge changes those counts or settings. The effect of a push, pop, register write or soft reset is visible one edge later. A sticky flag, and the `irq` it drives, appears one edge after its condition is seen. The bench drives inputs just after the falling edge. Its behavioural model advances exactly one edge per cycle, and every output is compared against the model each cycle before the next edge.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_FSTAT = 3'd1,
    A_IEN   = 3'd2,
    A_ISTS  = 3'd3,
    A_TXD   = 3'd4,
    A_RXD   = 3'd5
  } addr_e;

  localparam int B_RXDMA = 8;
  localparam int B_RXRST = 15;
  localparam int B_TXDMA = 24;
  localparam int B_TXRST = 31;

  localparam int EV_RXRDY = 0;
  localparam int EV_TXREQ = 4;
  localparam int EV_RXOVF = 8;
  localparam int EV_DONE  = 12;

  typedef struct packed {
    logic done;
    logic ovf;
    logic txreq;
    logic rxrdy;
  } ev_t;

  function automatic logic [31:0] ev_to_word(ev_t e);
    logic [31:0] w;
    w = '0;
    w[EV_RXRDY] = e.rxrdy;
    w[EV_TXREQ] = e.txreq;
    w[EV_RXOVF] = e.ovf;
    w[EV_DONE]  = e.done;
    return w;
  endfunction

  function automatic ev_t word_to_ev(logic [31:0] w);
    ev_t e;
    e.rxrdy = w[EV_RXRDY];
    e.txreq = w[EV_TXREQ];
    e.ovf   = w[EV_RXOVF];
    e.done  = w[EV_DONE];
    return e;
  endfunction
endpackage

// File: rtl/tfp_byte_fifo.sv
module tfp_byte_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    pdata,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= pdata;
  end
endmodule

// File: rtl/tfp_trig_events.sv
module tfp_trig_events #(
  parameter int CW = 7,
  localparam int XW = 9
) (
  input  logic [CW-1:0] rx_cnt,
  input  logic [CW-1:0] tx_cnt,
  input  logic [7:0]    rx_trig,
  input  logic [7:0]    tx_trig,
  input  logic          rx_dma_en,
  input  logic          tx_dma_en,
  output logic          rx_lvl,
  output logic          tx_lvl,
  output logic          dma_rx_req,
  output logic          dma_tx_req
);
  logic [XW-1:0] rx_c, tx_c, rx_t, tx_t;

  assign rx_c = XW'(rx_cnt);
  assign tx_c = XW'(tx_cnt);
  assign rx_t = XW'(rx_trig);
  assign tx_t = XW'(tx_trig);

  assign rx_lvl     = (rx_c >= rx_t);
  assign tx_lvl     = (tx_c <= tx_t);
  assign dma_rx_req = rx_lvl && rx_dma_en;
  assign dma_tx_req = tx_lvl && tx_dma_en;
endmodule

// File: rtl/tfp_irq_flags.sv
module tfp_irq_flags
  import tfp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ev_t  set,
  input  ev_t  clr,
  input  ev_t  en,
  output ev_t  sts,
  output logic irq
);
  ev_t sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr) | set;
  end

  assign sts = sts_q;
  assign irq = |(sts_q & en);
endmodule

// File: rtl/trig_fifo_pair.sv
module trig_fifo_pair
  import tfp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_in_valid,
  input  logic [7:0]  rx_in_data,
  input  logic        xfer_done,
  output logic        irq,
  output logic        dma_rx_req,
  output logic        dma_tx_req
);
  addr_e a;
  assign a = addr_e'(reg_addr);

  logic [7:0] rx_trig_q, tx_trig_q;
  logic       rx_dma_q, tx_dma_q, rx_rst_q, tx_rst_q;
  ev_t        ien_q;

  logic wr_ctrl, rx_clr, tx_clr, tx_push, rx_pop;
  assign wr_ctrl = reg_wr && (a == A_CTRL);
  assign rx_clr  = wr_ctrl && reg_wdata[B_RXRST];
  assign tx_clr  = wr_ctrl && reg_wdata[B_TXRST];
  assign tx_push = reg_wr && (a == A_TXD);
  assign rx_pop  = reg_rd && (a == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig_q <= '0;
      tx_trig_q <= '0;
      rx_dma_q  <= 1'b0;
      tx_dma_q  <= 1'b0;
      rx_rst_q  <= 1'b0;
      tx_rst_q  <= 1'b0;
      ien_q     <= '0;
    end else begin
      rx_rst_q <= rx_clr;
      tx_rst_q <= tx_clr;
      if (wr_ctrl) begin
        rx_trig_q <= reg_wdata[7:0];
        tx_trig_q <= reg_wdata[23:16];
        rx_dma_q  <= reg_wdata[B_RXDMA];
        tx_dma_q  <= reg_wdata[B_TXDMA];
      end
      if (reg_wr && (a == A_IEN)) ien_q <= word_to_ev(reg_wdata);
    end
  end

  logic [7:0]    tx_head, rx_head;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty;

  tfp_byte_fifo #(.DEPTH(DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .pdata(reg_wdata[7:0]),
    .pop(tx_valid && tx_ready),
    .head(tx_head), .cnt(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  tfp_byte_fifo #(.DEPTH(DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_in_valid), .pdata(rx_in_data),
    .pop(rx_pop),
    .head(rx_head), .cnt(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid = !tx_empty;
  assign tx_data  = tx_head;

  logic rx_lvl, tx_lvl;
  tfp_trig_events #(.CW(CW)) u_evt (
    .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_trig(rx_trig_q), .tx_trig(tx_trig_q),
    .rx_dma_en(rx_dma_q), .tx_dma_en(tx_dma_q),
    .rx_lvl(rx_lvl), .tx_lvl(tx_lvl),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  ev_t ev_set, ev_clr, ev_sts;
  always_comb begin
    ev_set.rxrdy = rx_lvl;
    ev_set.txreq = tx_lvl;
    ev_set.ovf   = rx_in_valid && rx_full;
    ev_set.done  = xfer_done;
  end
  assign ev_clr = (reg_wr && (a == A_ISTS)) ? word_to_ev(reg_wdata) : '0;

  tfp_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .set(ev_set), .clr(ev_clr), .en(ien_q),
    .sts(ev_sts), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (a)
      A_CTRL:  reg_rdata = {tx_rst_q, 6'b0, tx_dma_q, tx_trig_q,
                            rx_rst_q, 6'b0, rx_dma_q, rx_trig_q};
      A_FSTAT: reg_rdata = {8'b0, 8'(tx_cnt), 8'b0, 8'(rx_cnt)};
      A_IEN:   reg_rdata = ev_to_word(ien_q);
      A_ISTS:  reg_rdata = ev_to_word(ev_sts);
      A_RXD:   reg_rdata = {24'b0, (rx_empty ? 8'h00 : rx_head)};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_fifo_pair_chk.sv
module trig_fifo_pair_chk #(
  parameter int DEPTH = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_in_valid,
  input logic          irq,
  input logic          dma_rx_req,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          ovf_flag
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);

  // R3: an offered byte is held until taken (unless the TX FIFO is flushed)
  a_r3_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !(ctrl_wr && reg_wdata[31]) |=> tx_valid && $stable(tx_data));

  // R9: RX DMA request off after its enable is written 0
  a_r9_rx_dma_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !reg_wdata[8] |=> !dma_rx_req);

  // R12: RX soft reset empties the FIFO at the write edge
  a_r12_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[15] |=> rx_cnt == '0);

  // R12: TX soft reset empties the FIFO at the write edge
  a_r12_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[31] |=> tx_cnt == '0);

  // R11: all enables cleared means no interrupt
  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd2 && !reg_wdata[0] && !reg_wdata[4] && !reg_wdata[8] && !reg_wdata[12]
    |=> !irq);

  // R4: a push into a full RX FIFO raises the overflow flag
  a_r4_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_cnt == CW'(DEPTH) && !(ctrl_wr && reg_wdata[15]) |=> ovf_flag);

  // R6: counts never exceed the depth
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH));
endmodule

bind trig_fifo_pair trig_fifo_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_in_valid(rx_in_valid), .irq(irq),
  .dma_rx_req(dma_rx_req), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .ovf_flag(ev_sts.ovf)
);

// File: tb/trig_fifo_pair_tb.sv
module trig_fifo_pair_tb;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_in_valid = 1'b0;
  logic [7:0]  rx_in_data = '0;
  logic        xfer_done = 1'b0;
  logic        irq, dma_rx_req, dma_tx_req;

  always #10 clk = ~clk;

  trig_fifo_pair #(.DEPTH(DEPTH)) u_dut (.*);

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference
  byte unsigned txq[$];
  byte unsigned rxq[$];
  int  m_rx_trig = 0, m_tx_trig = 0;
  bit  m_rx_dma = 0, m_tx_dma = 0, m_rx_rst = 0, m_tx_rst = 0;
  bit [3:0] m_ien = '0;   // {done, ovf, txreq, rxrdy}
  bit [3:0] m_sts = '0;

  function automatic logic [31:0] flags_word(bit [3:0] f);
    logic [31:0] w = '0;
    w[0] = f[0]; w[4] = f[1]; w[8] = f[2]; w[12] = f[3];
    return w;
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] w = '0;
    case (reg_addr)
      3'd0: begin
        w[7:0] = 8'(m_rx_trig); w[8] = m_rx_dma; w[15] = m_rx_rst;
        w[23:16] = 8'(m_tx_trig); w[24] = m_tx_dma; w[31] = m_tx_rst;
      end
      3'd1: begin w[7:0] = 8'(rxq.size()); w[23:16] = 8'(txq.size()); end
      3'd2: w = flags_word(m_ien);
      3'd3: w = flags_word(m_sts);
      3'd5: if (rxq.size() > 0) w[7:0] = rxq[0];
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic string addr_tag();
    case (reg_addr)
      3'd0: return "R1/R12";
      3'd1: return "R6";
      3'd2: return "R11";
      3'd3: return "R10";
      3'd5: return "R5";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // compare, then advance model by the coming edge, then wait for the falling edge
  task automatic cyc();
    bit rl, tl, ovf;
    int txn, rxn;
    bit [3:0] clr;
    #1;
    rl = rxq.size() >= m_rx_trig;   // R7
    tl = txq.size() <= m_tx_trig;   // R8
    check(addr_tag(), reg_rdata, exp_rdata());
    check("R3 valid", 32'(tx_valid), 32'(txq.size() > 0));
    if (txq.size() > 0) check("R3 data", 32'(tx_data), 32'(txq[0]));
    check("R9 rx", 32'(dma_rx_req), 32'(rl && m_rx_dma));
    check("R9 tx", 32'(dma_tx_req), 32'(tl && m_tx_dma));
    check("R11 irq", 32'(irq), 32'(|(m_sts & m_ien)));
    if (rst_n) begin
      txn = txq.size(); rxn = rxq.size();
      if (txn > 0 && tx_ready) void'(txq.pop_front());
      if (reg_wr && reg_addr == 3'd4 && txn < DEPTH) txq.push_back(reg_wdata[7:0]); // R2
      if (reg_rd && reg_addr == 3'd5 && rxn > 0) void'(rxq.pop_front());           // R5
      ovf = 0;
      if (rx_in_valid) begin                                                         // R4
        if (rxn < DEPTH) rxq.push_back(rx_in_data); else ovf = 1;
      end
      clr = (reg_wr && reg_addr == 3'd3) ?
            {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]} : 4'b0;
      m_sts = (m_sts & ~clr) | {xfer_done, ovf, tl, rl};                             // R13
      m_rx_rst = 0; m_tx_rst = 0;
      if (reg_wr && reg_addr == 3'd0) begin
        m_rx_trig = reg_wdata[7:0];  m_rx_dma = reg_wdata[8];
        m_tx_trig = reg_wdata[23:16]; m_tx_dma = reg_wdata[24];
        if (reg_wdata[15]) begin m_rx_rst = 1; rxq.delete(); end                     // R12
        if (reg_wdata[31]) begin m_tx_rst = 1; txq.delete(); end
      end
      if (reg_wr && reg_addr == 3'd2)
        m_ien = {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]};
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    reg_wr = 0; reg_rd = 0; rx_in_valid = 0; xfer_done = 0;
  endtask

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    reg_addr = ad; reg_wdata = d; reg_wr = 1; cyc(); reg_wr = 0;
  endtask

  task automatic look(input logic [2:0] ad);
    reg_addr = ad; cyc();
  endtask

  task automatic rd_pop();
    reg_addr = 3'd5; reg_rd = 1; cyc(); reg_rd = 0;
  endtask

  function automatic logic [31:0] ctrl(int rxt, bit rxd, bit rxr, int txt, bit txd, bit txr);
    logic [31:0] w = '0;
    w[7:0] = 8'(rxt); w[8] = rxd; w[15] = rxr;
    w[23:16] = 8'(txt); w[24] = txd; w[31] = txr;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // reset state
    look(3'd0); look(3'd1); look(3'd3);
    rst_n = 1;
    look(3'd3);
    // R1: program triggers, read back
    wr(3'd0, ctrl(4, 0, 0, 2, 0, 0)); look(3'd0);
    wr(3'd2, 32'h0000_1111); look(3'd2);
    // R10: clear all flags; TX request still holds so it re-sets
    wr(3'd3, 32'h0000_1111); look(3'd3);
    // R2/R3: push bytes with the shifter stalled, then drain with gaps
    tx_ready = 0;
    for (int i = 0; i < 5; i++) wr(3'd4, 32'hA0 + i);
    look(3'd1);
    for (int i = 0; i < 10; i++) begin tx_ready = i[0]; look(3'd1); end
    tx_ready = 0;
    // R2: overfill TX; extra bytes dropped
    for (int i = 0; i < DEPTH + 3; i++) wr(3'd4, 32'(i * 3));
    look(3'd1);
    // R9/R8: TX DMA with trigger DEPTH-4, drain until the request rises
    wr(3'd0, ctrl(4, 0, 0, DEPTH - 4, 1, 0));
    tx_ready = 1;
    for (int i = 0; i < 8; i++) look(3'd1);
    // R12: TX soft reset while popping
    wr(3'd0, ctrl(4, 0, 0, 2, 0, 1)); look(3'd0); look(3'd1);
    tx_ready = 0;
    // R4/R7: RX pushes cross the trigger
    wr(3'd3, 32'h0000_1111);
    for (int i = 0; i < 6; i++) begin
      rx_in_valid = 1; rx_in_data = 8'h50 + 8'(i); look(3'd3);
    end
    rx_in_valid = 0; look(3'd1);
    // R5: pop some, then push while popping
    rd_pop(); rd_pop();
    rx_in_valid = 1; rx_in_data = 8'h77; rd_pop(); rx_in_valid = 0;
    // R4: fill past full to overflow
    for (int i = 0; i < DEPTH; i++) begin
      rx_in_valid = 1; rx_in_data = 8'(i); look(3'd1);
    end
    rx_in_valid = 0; look(3'd3);
    // R10: clear overflow with no new push
    wr(3'd3, 32'h0000_0100); look(3'd3);
    // R9: RX DMA on with trigger DEPTH-2
    wr(3'd0, ctrl(DEPTH - 2, 1, 0, 2, 0, 0));
    for (int i = 0; i < 5; i++) rd_pop();
    // R12: RX soft reset with simultaneous push: clear wins
    rx_in_valid = 1; rx_in_data = 8'hEE;
    wr(3'd0, ctrl(1, 1, 1, 2, 0, 0)); rx_in_valid = 0;
    look(3'd0); look(3'd1);
    // R5: read of empty returns 0 and removes nothing
    rd_pop(); look(3'd1);
    // R13: transfer-done pulse
    wr(3'd3, 32'h0000_1111);
    xfer_done = 1; look(3'd3); xfer_done = 0; look(3'd3);
    // R11: enables off silence the interrupt
    wr(3'd2, 32'h0); look(3'd3);
    wr(3'd2, 32'h0000_1000); look(3'd2);
    quiet();
    for (int i = 0; i < 4; i++) look(3'd3);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule